// File: doc/BRIEF.md
# Compare-Match General Purpose Timer

This block is a register-mapped up-counting timer for a general purpose peripheral subsystem. A prescaler divides the input clock, and each prescaler tick advances a counter. Three compare registers are checked against the counter on every tick. A match sets a per-channel flag. When the counter wraps past its all-ones value it sets a rollover flag. Software picks a mask of these flags, and any masked flag that is set holds a single level interrupt high until software clears it.

Two counting modes exist. In free-running mode the counter wraps only at its maximum value. In restart mode the counter also returns to zero on the tick where it equals compare channel 1, which gives a programmable period. A control bit decides whether starting the timer clears the counter and prescaler. A self-clearing control bit restores every register to its reset value. Registers are reached through a simple word bus with an address, a write strobe, write data and combinational read data.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the registers read as follows. Control (address 0), prescale (1), status (2), interrupt enable (3) and count (7) read 0. Compare 1, 2 and 3 (addresses 4, 5, 6) read all ones of the counter width. The irq output is 0.
- R2: The counter advances only while control bit 0 is 1. With prescale value N in bits 11:0 of address 1, it advances once every N+1 clock cycles. While control bit 0 is 0, both the counter and the prescaler hold.
- R3: On a tick where the count is all ones, the counter goes to 0 and status bit 5 (rollover) is set. This happens in either mode. Control bit 9 = 1 selects free-running mode.
- R4: With control bit 9 = 0 (restart mode), on a tick where the count equals compare 1, the counter goes to 0.
- R5: On a tick where the count equals compare k, status bit k-1 is set (bits 0, 1, 2 for channels 1, 2, 3). This happens in both modes.
- R6: Writing status clears each bit written as 1. Bits written as 0 keep their value. A flag that sets in the same cycle stays set.
- R7: irq is high exactly while some status bit is 1 and the interrupt-enable bit at the same position (0, 1, 2 or 5) is 1.
- R8: A control write that sets bit 0 while the timer is stopped, with bit 1 also written as 1, clears the counter and prescaler. With bit 1 written as 0, counting resumes from the held value. Control reads back only bits 0, 1 and 9.
- R9: A control write with bit 15 set returns every register, the counter, the prescaler and the flags to their R1 values. The other bits of that write are ignored, and bit 15 reads back as 0.
- R10: Writing compare 1 clears the counter when in restart mode. In free-running mode, writing compare 1 leaves the count unchanged.
- R11: Writes to the count register (address 7) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench walks the counter through a full wrap on a narrowed counter. A design that skips the all-ones value, or forgets the rollover flag, shows a wrong count or a missing status bit 5. Restart mode is run with compare 1 set small, so an off-by-one compare gives the wrong period. Writing compare 1 in each mode catches a design that clears the count in the wrong mode. Writing status with set-and-clear collisions, writing the read-only count, and a software reset mid-run each catch a register that keeps or loses state wrongly. Stopping and restarting with both settings of the clear-on-start bit shows whether the prescaler phase and the count resume or restart as intended.

// File: rtl/cmp_timer_pkg.sv
// Package: shared register selects, bit positions and widths for the timer.
// Assumes a word-addressed bus with 3 address bits.
package cmp_timer_pkg;
    localparam int ADDR_W  = 3;
    localparam int NUM_CMP = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 3'd0,
        SEL_PSC  = 3'd1,
        SEL_STAT = 3'd2,
        SEL_IEN  = 3'd3,
        SEL_CMP1 = 3'd4,
        SEL_CMP2 = 3'd5,
        SEL_CMP3 = 3'd6,
        SEL_CNT  = 3'd7
    } reg_sel_e;

    localparam int CTL_RUN     = 0;
    localparam int CTL_CLRMODE = 1;
    localparam int CTL_FREE    = 9;
    localparam int CTL_SWR     = 15;

    localparam int ST_W    = 6;
    localparam int ST_ROLL = 5;
    localparam logic [ST_W-1:0] ST_MASK = 6'h27;
endpackage

// File: rtl/cmp_timer_prescale.sv
// Prescaler: produces one tick every div+1 cycles while run is high.
// Assumes clear has priority over counting; holds its phase while stopped.
module cmp_timer_prescale #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;

    assign tick = run && (phase_q == div);

    // Phase counter: wraps at div, frozen when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == div) ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/cmp_timer_counter.sv
// Main counter: advances on tick, wraps at all ones, and in restart mode
// returns to zero on a match with the period value. Clear wins over tick.
module cmp_timer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             free_mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             rollover
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    assign count    = cnt_q;
    assign rollover = tick && (cnt_q == CNT_MAX);

    // Count register: clear, wrap, restart or increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == CNT_MAX || (!free_mode && cnt_q == period)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmp_timer_flags.sv
// Flag logic: per-channel compare match and rollover set status bits,
// which software clears by writing ones. A set beats a same-cycle clear.
module cmp_timer_flags
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            swr,
    input  logic                            tick,
    input  logic                            rollover,
    input  logic [CNT_W-1:0]                count,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_vals,
    input  logic                            clr_en,
    input  logic [ST_W-1:0]                 clr_bits,
    output logic [ST_W-1:0]                 status
);
    logic [NUM_CMP-1:0] hit;
    logic [ST_W-1:0]    set_bits;
    logic [ST_W-1:0]    keep_mask;
    logic [ST_W-1:0]    st_q;

    genvar k;
    generate
        for (k = 0; k < NUM_CMP; k++) begin : g_match
            assign hit[k] = tick && (count == cmp_vals[k]);
        end
    endgenerate

    // Gather the flags raised this cycle.
    always_comb begin
        set_bits = '0;
        set_bits[NUM_CMP-1:0] = hit;
        set_bits[ST_ROLL] = rollover;
    end

    assign keep_mask = clr_en ? ~clr_bits : '1;
    assign status    = st_q;

    // Status register: write-one-to-clear, sets take priority.
    always_ff @(posedge clk) begin
        if (!rst_n || swr) begin
            st_q <= '0;
        end else begin
            st_q <= ((st_q & keep_mask) | set_bits) & ST_MASK;
        end
    end
endmodule

// File: rtl/cmp_timer.sv
// Top: register file, bus decode and read mux for the compare-match timer.
// Assumes DATA_W >= 16 and DATA_W >= CNT_W; reads are combinational.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CMP_RST = '1;

    logic                          run_q;
    logic                          clrmode_q;
    logic                          free_q;
    logic [PRE_W-1:0]              psc_q;
    logic [ST_W-1:0]               ien_q;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;

    logic              wr_ctrl;
    logic              swr;
    logic              start_clr;
    logic              cmp1_clr;
    logic              wr_stat;
    logic              tick;
    logic              rollover;
    logic [CNT_W-1:0]  cnt_q;
    logic [ST_W-1:0]   status_q;

    // Write decode for side effects.
    always_comb begin
        wr_ctrl   = bus_we && (bus_addr == SEL_CTRL);
        swr       = wr_ctrl && bus_wdata[CTL_SWR];
        start_clr = wr_ctrl && !swr && bus_wdata[CTL_RUN]
                    && bus_wdata[CTL_CLRMODE] && !run_q;
        cmp1_clr  = bus_we && (bus_addr == SEL_CMP1) && !free_q;
        wr_stat   = bus_we && (bus_addr == SEL_STAT);
    end

    // Register file: control, prescale, enable mask and compare values.
    always_ff @(posedge clk) begin
        if (!rst_n || swr) begin
            run_q     <= 1'b0;
            clrmode_q <= 1'b0;
            free_q    <= 1'b0;
            psc_q     <= '0;
            ien_q     <= '0;
            for (int i = 0; i < NUM_CMP; i++) cmp_q[i] <= CMP_RST;
        end else if (bus_we) begin
            if (bus_addr == SEL_CTRL) begin
                run_q     <= bus_wdata[CTL_RUN];
                clrmode_q <= bus_wdata[CTL_CLRMODE];
                free_q    <= bus_wdata[CTL_FREE];
            end
            if (bus_addr == SEL_PSC) psc_q <= bus_wdata[PRE_W-1:0];
            if (bus_addr == SEL_IEN) ien_q <= bus_wdata[ST_W-1:0] & ST_MASK;
            for (int i = 0; i < NUM_CMP; i++) begin
                if (bus_addr == ADDR_W'(int'(SEL_CMP1) + i)) begin
                    cmp_q[i] <= bus_wdata[CNT_W-1:0];
                end
            end
        end
    end

    cmp_timer_prescale #(.PRE_W(PRE_W)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .clear (swr || start_clr),
        .div   (psc_q),
        .tick  (tick)
    );

    cmp_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (swr || start_clr || cmp1_clr),
        .tick      (tick),
        .free_mode (free_q),
        .period    (cmp_q[0]),
        .count     (cnt_q),
        .rollover  (rollover)
    );

    cmp_timer_flags #(.CNT_W(CNT_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .swr      (swr),
        .tick     (tick),
        .rollover (rollover),
        .count    (cnt_q),
        .cmp_vals (cmp_q),
        .clr_en   (wr_stat),
        .clr_bits (bus_wdata[ST_W-1:0]),
        .status   (status_q)
    );

    // Combined interrupt level.
    assign irq = |(status_q & ien_q);

    // Read mux, zero-extending every field.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            SEL_CTRL: begin
                bus_rdata[CTL_RUN]     = run_q;
                bus_rdata[CTL_CLRMODE] = clrmode_q;
                bus_rdata[CTL_FREE]    = free_q;
            end
            SEL_PSC:  bus_rdata[PRE_W-1:0] = psc_q;
            SEL_STAT: bus_rdata[ST_W-1:0]  = status_q;
            SEL_IEN:  bus_rdata[ST_W-1:0]  = ien_q;
            SEL_CMP1: bus_rdata[CNT_W-1:0] = cmp_q[0];
            SEL_CMP2: bus_rdata[CNT_W-1:0] = cmp_q[1];
            SEL_CMP3: bus_rdata[CNT_W-1:0] = cmp_q[2];
            default:  bus_rdata[CNT_W-1:0] = cnt_q;
        endcase
    end
endmodule

// File: rtl/cmp_timer_sva.sv
// Checker: temporal properties of the timer, bound into cmp_timer.
module cmp_timer_sva
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              run_q,
    input logic              free_q,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cmp1,
    input logic [ST_W-1:0]   status_q,
    input logic [ST_W-1:0]   ien_q,
    input logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !bus_we) |=> $stable(cnt_q));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

    // R3
    wrap_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == CNT_MAX && !bus_we) |=> (cnt_q == '0 && status_q[ST_ROLL]));

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !free_q && cnt_q == cmp1 && !bus_we) |=> (cnt_q == '0 && status_q[0]));

    // R9
    swr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_CTRL && bus_wdata[CTL_SWR]) |=> (cnt_q == '0 && status_q == '0 && !irq));

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
endmodule

bind cmp_timer cmp_timer_sva #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .run_q     (run_q),
    .free_q    (free_q),
    .tick      (tick),
    .cnt_q     (cnt_q),
    .cmp1      (cmp_q[0]),
    .status_q  (status_q),
    .ien_q     (ien_q),
    .irq       (irq)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
    localparam int CW   = 10;
    localparam int PW   = 12;
    localparam int MAXV = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  live = 0;
    bit  finished = 0;

    // reference model state
    int m_run, m_clrm, m_free, m_psc, m_pcnt, m_ien, m_cnt, m_st;
    int m_cmp[3];

    always #5 clk = ~clk;

    cmp_timer #(.CNT_W(CW), .PRE_W(PW), .DATA_W(32)) u_cmp_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wd),
        .bus_rdata (rd),
        .irq       (irq_o)
    );

    task automatic m_reset();
        m_run = 0; m_clrm = 0; m_free = 0; m_psc = 0; m_pcnt = 0;
        m_ien = 0; m_cnt = 0; m_st = 0;
        for (int k = 0; k < 3; k++) m_cmp[k] = MAXV;
    endtask

    task automatic m_step();
        bit tk;
        int setb, ncnt, npcnt, nst;
        tk = (m_run != 0) && (m_pcnt == m_psc);
        setb = 0;
        if (tk) begin
            for (int k = 0; k < 3; k++) if (m_cnt == m_cmp[k]) setb |= (1 << k);
            if (m_cnt == MAXV) setb |= 32;
        end
        ncnt = m_cnt;
        npcnt = m_pcnt;
        if (m_run != 0) npcnt = (m_pcnt == m_psc) ? 0 : m_pcnt + 1;
        if (tk) ncnt = (m_cnt == MAXV || (m_free == 0 && m_cnt == m_cmp[0])) ? 0 : m_cnt + 1;
        nst = m_st | setb;
        if (we) begin
            case (addr)
                3'd0: begin
                    if (wd[15]) begin
                        m_reset();
                        return;
                    end
                    if (wd[0] && wd[1] && m_run == 0) begin ncnt = 0; npcnt = 0; end
                    m_run = wd[0]; m_clrm = wd[1]; m_free = wd[9];
                end
                3'd1: m_psc = int'(wd[PW-1:0]);
                3'd2: nst = (m_st & ~int'(wd[5:0])) | setb;
                3'd3: m_ien = int'(wd[5:0]) & 32'h27;
                3'd4: begin
                    if (m_free == 0) ncnt = 0;
                    m_cmp[0] = int'(wd[CW-1:0]);
                end
                3'd5: m_cmp[1] = int'(wd[CW-1:0]);
                3'd6: m_cmp[2] = int'(wd[CW-1:0]);
                default: ;
            endcase
        end
        m_cnt = ncnt; m_pcnt = npcnt; m_st = nst & 32'h27;
    endtask

    function automatic int m_read(int a);
        case (a)
            0: return m_run | (m_clrm << 1) | (m_free << 9);
            1: return m_psc;
            2: return m_st;
            3: return m_ien;
            4: return m_cmp[0];
            5: return m_cmp[1];
            6: return m_cmp[2];
            default: return m_cnt;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            0: return "R8";
            1: return "R2";
            2: return "R5";
            3: return "R7";
            4, 5, 6: return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // model update on every rising edge
    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else m_step();
    end

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (live && !finished) begin
            chk(tag_of(int'(addr)), rd, 32'(m_read(int'(addr))));
            chk("R7", {31'd0, irq_o}, {31'd0, (m_st & m_ien) != 0});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wd = d; we = 1'b1;
        @(posedge clk);
        #2;
        we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic rdv(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] c;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        live = 1;

        // R1 reset values
        rdv(3'd0, v); chk("R1 ctrl", v, 32'h0);
        rdv(3'd2, v); chk("R1 status", v, 32'h0);
        rdv(3'd4, v); chk("R1 cmp1", v, 32'(MAXV));
        rdv(3'd6, v); chk("R1 cmp3", v, 32'(MAXV));
        rdv(3'd7, v); chk("R1 count", v, 32'h0);
        chk("R1 irq", {31'd0, irq_o}, 32'h0);

        // R3 R5: full wrap in free-running mode
        wr(3'd4, 32'd100); wr(3'd5, 32'd200); wr(3'd6, 32'd300);
        wr(3'd0, 32'h203);
        idle(1024);
        rdv(3'd7, v); chk("R3 wrap count", v, 32'h0);
        rdv(3'd2, v); chk("R5 R3 status after wrap", v, 32'h27);
        chk("R7 irq masked", {31'd0, irq_o}, 32'h0);
        wr(3'd3, 32'h20);
        chk("R7 irq on rollover", {31'd0, irq_o}, 32'h1);
        wr(3'd2, 32'h20);
        rdv(3'd2, v); chk("R6 w1c", v, 32'h07);
        chk("R7 irq after clear", {31'd0, irq_o}, 32'h0);
        wr(3'd2, 32'h00);
        rdv(3'd2, v); chk("R6 write zero", v, 32'h07);
        wr(3'd3, 32'h01);
        chk("R7 irq channel 1", {31'd0, irq_o}, 32'h1);

        // R9 software reset
        wr(3'd0, 32'h8203);
        rdv(3'd0, v); chk("R9 ctrl", v, 32'h0);
        rdv(3'd2, v); chk("R9 status", v, 32'h0);
        rdv(3'd3, v); chk("R9 ien", v, 32'h0);
        rdv(3'd4, v); chk("R9 cmp1", v, 32'(MAXV));
        rdv(3'd7, v); chk("R9 count", v, 32'h0);
        chk("R9 irq", {31'd0, irq_o}, 32'h0);

        // R4 restart mode with period 5
        wr(3'd4, 32'd5);
        wr(3'd0, 32'h003);
        idle(6);
        rdv(3'd7, v); chk("R4 restart count", v, 32'h0);
        rdv(3'd2, v); chk("R4 restart flag", v, 32'h01);
        idle(3);
        rdv(3'd7, v); chk("R4 count after restart", v, 32'd3);
        wr(3'd4, 32'd8);
        rdv(3'd7, v); chk("R10 cmp1 write restart", v, 32'h0);
        idle(2);
        wr(3'd0, 32'h201);
        rdv(3'd7, v); chk("R2 free switch", v, 32'd3);
        wr(3'd4, 32'd50);
        rdv(3'd7, v); chk("R10 cmp1 write free", v, 32'd4);

        // R11 count is read-only
        wr(3'd0, 32'h200);
        rdv(3'd7, c); chk("R2 stop", c, 32'd5);
        wr(3'd7, 32'h55);
        rdv(3'd7, v); chk("R11 count write ignored", v, c);

        // R2 R8 prescale and start modes
        wr(3'd1, 32'd2);
        wr(3'd0, 32'h203);
        idle(30);
        rdv(3'd7, v); chk("R2 prescale 2", v, 32'd10);
        wr(3'd0, 32'h200);
        idle(10);
        rdv(3'd7, v); chk("R2 hold while stopped", v, 32'd10);
        wr(3'd0, 32'h201);
        idle(2);
        rdv(3'd7, v); chk("R8 resume", v, 32'd11);
        wr(3'd0, 32'h200);
        wr(3'd0, 32'h203);
        rdv(3'd7, v); chk("R8 clear on start", v, 32'h0);

        // mixed traffic compared against the model every cycle
        for (int i = 0; i < 1500; i++) begin
            int a;
            logic [31:0] d;
            a = int'($urandom % 8);
            d = $urandom;
            if (a == 0) d = (d & 32'h203) | ((($urandom % 40) == 0) ? 32'h8000 : 32'h0);
            if (a == 1) d = d % 4;
            if (a >= 4 && a <= 6) d = d % 40;
            if (($urandom % 4) == 0) wr(3'(a), d);
            else begin
                addr = 3'(a);
                idle(1);
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL R2: watchdog expired, got running expected done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule